// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register Block

This block is the memory-mapped control face of an indexed-colour display controller. A host reaches it through a single-cycle request port with 32-bit data, and may use byte, halfword or word accesses. The address map is sparse. It holds a fixed identification word and a control word. It also holds a top-of-screen offset, a horizontal size kept in units of four pixels and a vertical size kept in units of half a line. There is a cursor position, three cursor colours, a 256-entry colour lookup table, a 512-row cursor bitmap and a strobe that clears everything.

The block feeds the pixel path through plain outputs: decoded size, depth, blanking and cursor-disable, cursor coordinates and three lookup ports, one each for the colour table, the cursor colours and the cursor bitmap. A narrow write is carried out as read, merge and write back of the containing word, so the merge always starts from what a read of that word would return. A single-cycle frame pulse raises a level interrupt. Any register write takes it down again.

Top module: `dispctl_regs`

## Requirements
- R1: The word at offset 0x000000 always reads 0x00000010, and writes to it change nothing.
- R2: A write of value v to offset 0x080118 sets the pixel-width output to v*4 (modulo 2^32); reading that offset returns width/4.
- R3: A write of value v to offset 0x080150 sets the line-count output to v/2 (rounded down); reading that offset returns lines*2.
- R4: Offset 0x080300 holds a 32-bit control word that reads back unchanged. Bit 10 drives the blank output and bit 23 the cursor-disable output. Bits 22:20 select the depth output in bits per pixel: codes 0..7 give 1, 2, 4, 8, 15, 16, 0, 0.
- R5: Offset 0x080400 (top of screen) and offset 0x080638 (cursor position) are 32-bit read/write words. Cursor x is position bits 31:12 and cursor y is bits 11:0.
- R6: Colour-table entry i is written at 0x080800+8*i (bit 2 of the address is ignored). Value bits 23:16, 15:8 and 7:0 are stored as red, green and blue, and the lookup port returns them as {r,g,b}. Reads of this region return zero.
- R7: Cursor colour k (k = 0..2) sits at 0x080508+8*k. Its 24 low bits are readable and writable and are also returned on the cursor-colour lookup port; select value 3 returns zero.
- R8: Cursor bitmap row j sits at 0x081000+8*j. Only the 16 low bits are stored, and reads return them zero-extended.
- R9: A byte or halfword write takes the containing word's read value, replaces only the addressed lane, and stores the result through the register's normal write rule. Sizes are encoded 0 = byte, 1 = halfword, 2 or 3 = word, and narrow write data sits in the low bits.
- R10: A byte read returns bits 8*(a mod 4)+7 : 8*(a mod 4) in bits 7:0. A halfword read returns the upper half when address bit 1 is set and the lower half otherwise. Both are zero-extended.
- R11: Any address outside the listed registers, including the display-timing words, reads zero, and a write to it changes no stored state.
- R12: A frame pulse sets the interrupt in the next cycle. Any register write clears it. A pulse in the same cycle as an ordinary write leaves it set, and reads leave it alone.
- R13: Any write to offset 0x180000 clears every stored value, every table entry and the interrupt, and it overrides a simultaneous frame pulse.
- R14: Read data appears on rd_data one cycle after a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 32 | Write data, narrow data in low bits |
| rd_data | output | 32 | Registered read data |
| frame_tick | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Frame interrupt level |
| width_px | output | 32 | Visible width in pixels |
| height_ln | output | 32 | Visible height in lines |
| top_ofs | output | 32 | Frame start offset |
| cursor_x | output | 20 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| depth_bpp | output | 5 | Decoded bits per pixel |
| blank | output | 1 | Force-blank control |
| cursor_off | output | 1 | Cursor-disable control |
| pal_idx | input | 8 | Colour-table lookup index |
| pal_rgb | output | 24 | Colour-table entry {r,g,b} |
| cpal_sel | input | 2 | Cursor colour select |
| cpal_rgb | output | 24 | Cursor colour {r,g,b} |
| cpat_idx | input | 9 | Cursor bitmap row index |
| cpat_row | output | 16 | Cursor bitmap row |

## Verification
The properties assume a frame pulse is never longer than one cycle and that a request is a single-cycle event whose address and data are valid while req_valid is high. The bench drives every request and pulse for exactly one clock, changes inputs only on falling edges, and never leaves a request pending across two edges. The properties also assume the reset strobe address is decoded from the word address alone. The bench therefore hits it only with word writes, including one that coincides with a frame pulse.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  // Byte offsets of the register map; the decoder and the pixel path rely on them.
  localparam int unsigned BASE_ID     = 32'h0000_0000;
  localparam int unsigned BASE_WIDTH  = 32'h0008_0118;
  localparam int unsigned BASE_HEIGHT = 32'h0008_0150;
  localparam int unsigned BASE_CTL    = 32'h0008_0300;
  localparam int unsigned BASE_TOP    = 32'h0008_0400;
  localparam int unsigned BASE_CPAL   = 32'h0008_0508;
  localparam int unsigned BASE_CPOS   = 32'h0008_0638;
  localparam int unsigned BASE_PAL    = 32'h0008_0800;
  localparam int unsigned BASE_CPAT   = 32'h0008_1000;
  localparam int unsigned BASE_RESET  = 32'h0018_0000;
  localparam int unsigned ENTRY_STRIDE = 8;

  localparam logic [31:0] ID_VALUE = 32'h0000_0010;

  localparam int CTL_BLANK_BIT  = 10;
  localparam int CTL_NOCURS_BIT = 23;
  localparam int CTL_DEPTH_LSB  = 20;

  typedef enum logic [3:0] {
    RG_NONE, RG_ID, RG_WIDTH, RG_HEIGHT, RG_CTL, RG_TOP,
    RG_CPOS, RG_CPAL, RG_PAL, RG_CPAT, RG_RESET
  } region_e;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_e;

  function automatic logic [4:0] depth_bits(input logic [2:0] code);
    logic [4:0] bits;
    case (code)
      3'd0:    bits = 5'd1;
      3'd1:    bits = 5'd2;
      3'd2:    bits = 5'd4;
      3'd3:    bits = 5'd8;
      3'd4:    bits = 5'd15;
      3'd5:    bits = 5'd16;
      default: bits = 5'd0;
    endcase
    return bits;
  endfunction

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
  import dispctl_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int PAL_N   = 256,
  parameter int CPAL_N  = 3,
  parameter int CPAT_N  = 512,
  parameter int PAL_IW  = 8,
  parameter int CPAL_IW = 2,
  parameter int CPAT_IW = 9
) (
  input  logic [ADDR_W-3:0]  word_addr,
  output region_e            region,
  output logic [PAL_IW-1:0]  pal_ix,
  output logic [CPAL_IW-1:0] cpal_ix,
  output logic [CPAT_IW-1:0] cpat_ix
);

  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(BASE_ID);
  localparam logic [ADDR_W-1:0] A_WIDTH  = ADDR_W'(BASE_WIDTH);
  localparam logic [ADDR_W-1:0] A_HEIGHT = ADDR_W'(BASE_HEIGHT);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(BASE_CTL);
  localparam logic [ADDR_W-1:0] A_TOP    = ADDR_W'(BASE_TOP);
  localparam logic [ADDR_W-1:0] A_CPOS   = ADDR_W'(BASE_CPOS);
  localparam logic [ADDR_W-1:0] A_RESET  = ADDR_W'(BASE_RESET);
  localparam logic [ADDR_W-1:0] A_PAL    = ADDR_W'(BASE_PAL);
  localparam logic [ADDR_W-1:0] A_PAL_E  = ADDR_W'(BASE_PAL + PAL_N * ENTRY_STRIDE);
  localparam logic [ADDR_W-1:0] A_CPAL   = ADDR_W'(BASE_CPAL);
  localparam logic [ADDR_W-1:0] A_CPAL_E = ADDR_W'(BASE_CPAL + CPAL_N * ENTRY_STRIDE);
  localparam logic [ADDR_W-1:0] A_CPAT   = ADDR_W'(BASE_CPAT);
  localparam logic [ADDR_W-1:0] A_CPAT_E = ADDR_W'(BASE_CPAT + CPAT_N * ENTRY_STRIDE);

  logic [ADDR_W-1:0] wa;
  logic in_pal, in_cpal, in_cpat;

  assign wa      = {word_addr, 2'b00};
  assign in_pal  = (wa >= A_PAL)  && (wa < A_PAL_E);
  assign in_cpal = (wa >= A_CPAL) && (wa < A_CPAL_E);
  assign in_cpat = (wa >= A_CPAT) && (wa < A_CPAT_E);

  // Table indices: one entry per stride, so the byte offset drops three bits.
  assign pal_ix  = PAL_IW'((wa - A_PAL) >> 3);
  assign cpal_ix = CPAL_IW'((wa - A_CPAL) >> 3);
  assign cpat_ix = CPAT_IW'((wa - A_CPAT) >> 3);

  always_comb begin
    region = RG_NONE;
    if (in_cpat) begin
      region = RG_CPAT;
    end else if (in_cpal) begin
      region = RG_CPAL;
    end else if (in_pal) begin
      region = RG_PAL;
    end else begin
      case (wa)
        A_ID:     region = RG_ID;
        A_WIDTH:  region = RG_WIDTH;
        A_HEIGHT: region = RG_HEIGHT;
        A_CTL:    region = RG_CTL;
        A_TOP:    region = RG_TOP;
        A_CPOS:   region = RG_CPOS;
        A_RESET:  region = RG_RESET;
        default:  region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dispctl_lanes.sv
module dispctl_lanes
  import dispctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd_lane
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  always_comb begin
    merged  = old_word;
    rd_lane = old_word;
    case (acc_e'(size))
      ACC_BYTE: begin
        merged[BYTE_W*lane +: BYTE_W] = wdata[BYTE_W-1:0];
        rd_lane = DATA_W'(old_word[BYTE_W*lane +: BYTE_W]);
      end
      ACC_HALF: begin
        merged[HALF_W*lane[1] +: HALF_W] = wdata[HALF_W-1:0];
        rd_lane = DATA_W'(old_word[HALF_W*lane[1] +: HALF_W]);
      end
      default: begin
        merged  = wdata;
        rd_lane = old_word;
      end
    endcase
  end

endmodule

// File: rtl/dispctl_rf.sv
module dispctl_rf #(
  parameter int N      = 256,
  parameter int W      = 24,
  parameter int IW     = 8,
  parameter bit BUS_RD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wd,
  input  logic [IW-1:0] lk_idx,
  output logic [W-1:0]  bus_q,
  output logic [W-1:0]  lk_q
);

  logic [W-1:0] mem [N];

  for (genvar e = 0; e < N; e++) begin : g_entry
    logic         en;
    logic [W-1:0] nxt;

    always_comb begin
      en  = clr || (we && (idx == IW'(e)));
      nxt = clr ? '0 : wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (en) begin
        mem[e] <= nxt;
      end
    end
  end

  assign lk_q = (int'(lk_idx) < N) ? mem[lk_idx] : '0;

  if (BUS_RD) begin : g_bus_rd
    assign bus_q = (int'(idx) < N) ? mem[idx] : '0;
  end else begin : g_bus_zero
    assign bus_q = '0;
  end

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int PAL_N        = 256,
  parameter int CPAL_N       = 3,
  parameter int CPAT_N       = 512,
  parameter int CPAT_W       = 16,
  parameter int RGB_W        = 24,
  parameter bit PAL_READABLE = 1'b0,
  localparam int PAL_IW  = $clog2(PAL_N),
  localparam int CPAL_IW = $clog2(CPAL_N),
  localparam int CPAT_IW = $clog2(CPAT_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic [31:0]        rd_data,
  input  logic               frame_tick,
  output logic               irq,
  output logic [31:0]        width_px,
  output logic [31:0]        height_ln,
  output logic [31:0]        top_ofs,
  output logic [19:0]        cursor_x,
  output logic [11:0]        cursor_y,
  output logic [4:0]         depth_bpp,
  output logic               blank,
  output logic               cursor_off,
  input  logic [PAL_IW-1:0]  pal_idx,
  output logic [RGB_W-1:0]   pal_rgb,
  input  logic [CPAL_IW-1:0] cpal_sel,
  output logic [RGB_W-1:0]   cpal_rgb,
  input  logic [CPAT_IW-1:0] cpat_idx,
  output logic [CPAT_W-1:0]  cpat_row
);

  localparam int DATA_W = 32;
  localparam int POS_Y_W = 12;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Address decode and lane handling.
  region_e            region;
  logic [PAL_IW-1:0]  pal_ix;
  logic [CPAL_IW-1:0] cpal_ix;
  logic [CPAT_IW-1:0] cpat_ix;
  logic [DATA_W-1:0]  old_word, merged, rd_lane;

  dispctl_decode #(
    .ADDR_W (ADDR_W), .PAL_N (PAL_N), .CPAL_N (CPAL_N), .CPAT_N (CPAT_N),
    .PAL_IW (PAL_IW), .CPAL_IW (CPAL_IW), .CPAT_IW (CPAT_IW)
  ) u_decode (
    .word_addr (req_addr[ADDR_W-1:2]),
    .region    (region),
    .pal_ix    (pal_ix),
    .cpal_ix   (cpal_ix),
    .cpat_ix   (cpat_ix)
  );

  dispctl_lanes #(.DATA_W (DATA_W)) u_lanes (
    .size     (req_size),
    .lane     (req_addr[1:0]),
    .wdata    (req_wdata),
    .old_word (old_word),
    .merged   (merged),
    .rd_lane  (rd_lane)
  );

  // Access qualifiers.
  logic wr_go, rd_go, clr_all;
  logic en_width, en_height, en_ctl, en_top, en_cpos;
  logic we_pal, we_cpal, we_cpat;

  always_comb begin
    wr_go     = req_valid && req_write;
    rd_go     = req_valid && !req_write;
    clr_all   = wr_go && (region == RG_RESET);
    en_width  = clr_all || (wr_go && (region == RG_WIDTH));
    en_height = clr_all || (wr_go && (region == RG_HEIGHT));
    en_ctl    = clr_all || (wr_go && (region == RG_CTL));
    en_top    = clr_all || (wr_go && (region == RG_TOP));
    en_cpos   = clr_all || (wr_go && (region == RG_CPOS));
    we_pal    = wr_go && (region == RG_PAL);
    we_cpal   = wr_go && (region == RG_CPAL);
    we_cpat   = wr_go && (region == RG_CPAT);
  end

  // Tables.
  logic [RGB_W-1:0]  pal_bus_q, cpal_bus_q;
  logic [CPAT_W-1:0] cpat_bus_q;

  dispctl_rf #(.N (PAL_N), .W (RGB_W), .IW (PAL_IW), .BUS_RD (PAL_READABLE)) u_pal (
    .clk (clk), .rst_n (rst_q), .clr (clr_all), .we (we_pal), .idx (pal_ix),
    .wd (merged[RGB_W-1:0]), .lk_idx (pal_idx), .bus_q (pal_bus_q), .lk_q (pal_rgb)
  );

  dispctl_rf #(.N (CPAL_N), .W (RGB_W), .IW (CPAL_IW), .BUS_RD (1'b1)) u_cpal (
    .clk (clk), .rst_n (rst_q), .clr (clr_all), .we (we_cpal), .idx (cpal_ix),
    .wd (merged[RGB_W-1:0]), .lk_idx (cpal_sel), .bus_q (cpal_bus_q), .lk_q (cpal_rgb)
  );

  dispctl_rf #(.N (CPAT_N), .W (CPAT_W), .IW (CPAT_IW), .BUS_RD (1'b1)) u_cpat (
    .clk (clk), .rst_n (rst_q), .clr (clr_all), .we (we_cpat), .idx (cpat_ix),
    .wd (merged[CPAT_W-1:0]), .lk_idx (cpat_idx), .bus_q (cpat_bus_q), .lk_q (cpat_row)
  );

  // Scalar registers.
  logic [DATA_W-1:0] width_q, height_q, ctl_q, top_q, cpos_q;
  logic [DATA_W-1:0] width_d, height_d, ctl_d, top_d, cpos_d;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] rdat_q;

  // Word as a read would return it: the starting point of every merge.
  always_comb begin
    case (region)
      RG_ID:     old_word = ID_VALUE;
      RG_WIDTH:  old_word = width_q >> 2;
      RG_HEIGHT: old_word = height_q << 1;
      RG_CTL:    old_word = ctl_q;
      RG_TOP:    old_word = top_q;
      RG_CPOS:   old_word = cpos_q;
      RG_CPAL:   old_word = DATA_W'(cpal_bus_q);
      RG_PAL:    old_word = DATA_W'(pal_bus_q);
      RG_CPAT:   old_word = DATA_W'(cpat_bus_q);
      default:   old_word = '0;
    endcase
  end

  always_comb begin
    width_d  = clr_all ? '0 : (merged << 2);
    height_d = clr_all ? '0 : (merged >> 1);
    ctl_d    = clr_all ? '0 : merged;
    top_d    = clr_all ? '0 : merged;
    cpos_d   = clr_all ? '0 : merged;
    if (clr_all) begin
      irq_d = 1'b0;
    end else if (frame_tick) begin
      irq_d = 1'b1;
    end else if (wr_go) begin
      irq_d = 1'b0;
    end else begin
      irq_d = irq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      width_q  <= '0;
      height_q <= '0;
      ctl_q    <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
      irq_q    <= 1'b0;
      rdat_q   <= '0;
    end else begin
      if (en_width)  width_q  <= width_d;
      if (en_height) height_q <= height_d;
      if (en_ctl)    ctl_q    <= ctl_d;
      if (en_top)    top_q    <= top_d;
      if (en_cpos)   cpos_q   <= cpos_d;
      irq_q <= irq_d;
      if (rd_go)     rdat_q   <= rd_lane;
    end
  end

  // Outputs to the host and the pixel path.
  assign rd_data    = rdat_q;
  assign irq        = irq_q;
  assign width_px   = width_q;
  assign height_ln  = height_q;
  assign top_ofs    = top_q;
  assign cursor_x   = cpos_q[DATA_W-1:POS_Y_W];
  assign cursor_y   = cpos_q[POS_Y_W-1:0];
  assign depth_bpp  = depth_bits(ctl_q[CTL_DEPTH_LSB +: 3]);
  assign blank      = ctl_q[CTL_BLANK_BIT];
  assign cursor_off = ctl_q[CTL_NOCURS_BIT];

endmodule

// File: rtl/dispctl_regs_chk.sv
module dispctl_regs_chk
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-3:0] wa_hi,
  input logic [31:0]       req_wdata,
  input logic              frame_tick,
  input logic              irq,
  input logic [31:0]       rd_data,
  input logic [31:0]       width_px,
  input logic              blank,
  input logic              cursor_off
);

  logic wr, rd, hit_rst, hit_width, hit_ctl, hit_id, is_word;

  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;
  assign is_word   = req_size[1];
  assign hit_rst   = (wa_hi == (ADDR_W-2)'(BASE_RESET >> 2));
  assign hit_width = (wa_hi == (ADDR_W-2)'(BASE_WIDTH >> 2));
  assign hit_ctl   = (wa_hi == (ADDR_W-2)'(BASE_CTL >> 2));
  assign hit_id    = (wa_hi == (ADDR_W-2)'(BASE_ID >> 2));

  // R12
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !(wr && hit_rst)) |=> irq);

  // R12
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !frame_tick) |=> !irq);

  // R13
  rst_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_rst) |=> (!irq && (width_px == 32'd0) && !blank && !cursor_off));

  // R2
  width_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_word && hit_width) |=> (width_px == ($past(req_wdata) << 2)));

  // R4
  ctl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_word && hit_ctl) |=>
      ((blank == $past(req_wdata[CTL_BLANK_BIT])) && (cursor_off == $past(req_wdata[CTL_NOCURS_BIT]))));

  // R1
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_word && hit_id) |=> (rd_data == ID_VALUE));

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rd_data));

endmodule

bind dispctl_regs dispctl_regs_chk #(.ADDR_W (ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .wa_hi      (req_addr[ADDR_W-1:2]),
  .req_wdata  (req_wdata),
  .frame_tick (frame_tick),
  .irq        (irq),
  .rd_data    (rd_data),
  .width_px   (width_px),
  .blank      (blank),
  .cursor_off (cursor_off)
);

// File: tb/dispctl_regs_tb.sv
module dispctl_regs_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [20:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic        frame_tick, irq;
  logic [31:0] width_px, height_ln, top_ofs;
  logic [19:0] cursor_x;
  logic [11:0] cursor_y;
  logic [4:0]  depth_bpp;
  logic        blank, cursor_off;
  logic [7:0]  pal_idx;
  logic [23:0] pal_rgb;
  logic [1:0]  cpal_sel;
  logic [23:0] cpal_rgb;
  logic [8:0]  cpat_idx;
  logic [15:0] cpat_row;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  dispctl_regs u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_size (req_size), .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_data (rd_data), .frame_tick (frame_tick), .irq (irq),
    .width_px (width_px), .height_ln (height_ln), .top_ofs (top_ofs),
    .cursor_x (cursor_x), .cursor_y (cursor_y), .depth_bpp (depth_bpp),
    .blank (blank), .cursor_off (cursor_off), .pal_idx (pal_idx), .pal_rgb (pal_rgb),
    .cpal_sel (cpal_sel), .cpal_rgb (cpal_rgb), .cpat_idx (cpat_idx), .cpat_row (cpat_row)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [20:0] addr;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 21'h000000, 32'h0000FFFF, 1'b0, 32'h0,        "R1 "},
    '{1'b0, 2'd2, 21'h000000, 32'h0,        1'b1, 32'h00000010, "R1 "},
    '{1'b0, 2'd0, 21'h000000, 32'h0,        1'b1, 32'h00000010, "R10"},
    '{1'b0, 2'd0, 21'h000001, 32'h0,        1'b1, 32'h00000000, "R10"},
    '{1'b1, 2'd2, 21'h080118, 32'h00000140, 1'b0, 32'h0,        "R2 "},
    '{1'b0, 2'd2, 21'h080118, 32'h0,        1'b1, 32'h00000140, "R2 "},
    '{1'b1, 2'd0, 21'h080119, 32'h00000002, 1'b0, 32'h0,        "R9 "},
    '{1'b0, 2'd2, 21'h080118, 32'h0,        1'b1, 32'h00000240, "R9 "},
    '{1'b1, 2'd2, 21'h080150, 32'h000003C1, 1'b0, 32'h0,        "R3 "},
    '{1'b0, 2'd2, 21'h080150, 32'h0,        1'b1, 32'h000003C0, "R3 "},
    '{1'b1, 2'd2, 21'h080300, 32'h00300400, 1'b0, 32'h0,        "R4 "},
    '{1'b0, 2'd2, 21'h080300, 32'h0,        1'b1, 32'h00300400, "R4 "},
    '{1'b0, 2'd0, 21'h080302, 32'h0,        1'b1, 32'h00000030, "R10"},
    '{1'b0, 2'd1, 21'h080302, 32'h0,        1'b1, 32'h00000030, "R10"},
    '{1'b0, 2'd1, 21'h080300, 32'h0,        1'b1, 32'h00000400, "R10"},
    '{1'b1, 2'd1, 21'h080302, 32'h00000080, 1'b0, 32'h0,        "R9 "},
    '{1'b0, 2'd2, 21'h080300, 32'h0,        1'b1, 32'h00800400, "R9 "},
    '{1'b1, 2'd2, 21'h080400, 32'hDEADBEEF, 1'b0, 32'h0,        "R5 "},
    '{1'b0, 2'd0, 21'h080403, 32'h0,        1'b1, 32'h000000DE, "R5 "},
    '{1'b1, 2'd2, 21'h080638, 32'h00123045, 1'b0, 32'h0,        "R5 "},
    '{1'b0, 2'd2, 21'h080638, 32'h0,        1'b1, 32'h00123045, "R5 "},
    '{1'b1, 2'd2, 21'h080510, 32'h00A1B2C3, 1'b0, 32'h0,        "R7 "},
    '{1'b0, 2'd2, 21'h080514, 32'h0,        1'b1, 32'h00A1B2C3, "R7 "},
    '{1'b1, 2'd2, 21'h080518, 32'hFF112233, 1'b0, 32'h0,        "R7 "},
    '{1'b0, 2'd2, 21'h080518, 32'h0,        1'b1, 32'h00112233, "R7 "},
    '{1'b1, 2'd2, 21'h081008, 32'h0001ABCD, 1'b0, 32'h0,        "R8 "},
    '{1'b0, 2'd2, 21'h081008, 32'h0,        1'b1, 32'h0000ABCD, "R8 "},
    '{1'b1, 2'd1, 21'h08100A, 32'h00005555, 1'b0, 32'h0,        "R9 "},
    '{1'b0, 2'd2, 21'h081008, 32'h0,        1'b1, 32'h0000ABCD, "R9 "},
    '{1'b1, 2'd2, 21'h080808, 32'h00102030, 1'b0, 32'h0,        "R6 "},
    '{1'b0, 2'd2, 21'h080808, 32'h0,        1'b1, 32'h00000000, "R6 "},
    '{1'b1, 2'd0, 21'h080811, 32'h00000077, 1'b0, 32'h0,        "R9 "},
    '{1'b1, 2'd2, 21'h080108, 32'h00001234, 1'b0, 32'h0,        "R11"},
    '{1'b0, 2'd2, 21'h080108, 32'h0,        1'b1, 32'h00000000, "R11"},
    '{1'b1, 2'd2, 21'h080520, 32'h0055AA00, 1'b0, 32'h0,        "R11"},
    '{1'b0, 2'd2, 21'h080520, 32'h0,        1'b1, 32'h00000000, "R11"},
    '{1'b0, 2'd1, 21'h080152, 32'h0,        1'b1, 32'h00000000, "R10"}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // One access, optionally with a frame pulse in the same cycle.
  task automatic bus(input bit wr, input logic [1:0] sz, input logic [20:0] a,
                     input logic [31:0] d, input bit tick);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_size   = sz;
    req_addr   = a;
    req_wdata  = d;
    frame_tick = tick;
    @(negedge clk);
    req_valid  = 1'b0;
    req_write  = 1'b0;
    frame_tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  function automatic logic [31:0] exp_depth(input int code);
    case (code)
      0: return 32'd1;
      1: return 32'd2;
      2: return 32'd4;
      3: return 32'd8;
      4: return 32'd15;
      5: return 32'd16;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; frame_tick = 1'b0;
    pal_idx = '0; cpal_sel = '0; cpat_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    check(32'(irq),       32'd0, "reset irq (R12)");
    check(width_px,       32'd0, "reset width (R2)");
    check(rd_data,        32'd0, "reset rd_data (R14)");
    check(32'(pal_rgb),   32'd0, "reset palette (R6)");
    check(32'(depth_bpp), 32'd1, "reset depth (R4)");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].data, 1'b0);
      if (VEC[i].chk) check(rd_data, VEC[i].exp, $sformatf("%s vector %0d", VEC[i].tag, i));
    end

    // Pixel-path outputs after the table
    check(width_px,        32'h00000900, "R2 width_px after byte merge");
    check(height_ln,       32'h000001E0, "R3 height_ln");
    check(32'(blank),      32'd1,        "R4 blank");
    check(32'(cursor_off), 32'd1,        "R4 cursor_off");
    check(32'(depth_bpp),  32'd1,        "R4 depth code 0");
    check(top_ofs,         32'hDEADBEEF, "R5 top_ofs");
    check(32'(cursor_x),   32'h00000123, "R5 cursor_x");
    check(32'(cursor_y),   32'h00000045, "R5 cursor_y");
    pal_idx = 8'd1; #1;
    check(32'(pal_rgb),    32'h00102030, "R6 palette entry 1");
    pal_idx = 8'd2; #1;
    check(32'(pal_rgb),    32'h00007700, "R9 palette byte merge from zero readback");
    pal_idx = 8'd0; #1;
    check(32'(pal_rgb),    32'h00000000, "R6 palette entry 0 untouched");
    cpal_sel = 2'd1; #1;
    check(32'(cpal_rgb),   32'h00A1B2C3, "R7 cursor colour 1");
    cpal_sel = 2'd2; #1;
    check(32'(cpal_rgb),   32'h00112233, "R7 cursor colour 2");
    cpal_sel = 2'd3; #1;
    check(32'(cpal_rgb),   32'h00000000, "R7 cursor colour select 3");
    cpat_idx = 9'd1; #1;
    check(32'(cpat_row),   32'h0000ABCD, "R8 cursor row 1");

    // Depth table
    for (int k = 0; k < 8; k++) begin
      bus(1'b1, 2'd2, 21'h080300, 32'(k) << 20, 1'b0);
      check(32'(depth_bpp), exp_depth(k), $sformatf("R4 depth code %0d", k));
    end

    // Read data holds across a write
    bus(1'b0, 2'd2, 21'h080400, 32'h0, 1'b0);
    check(rd_data, 32'hDEADBEEF, "R14 read top");
    bus(1'b1, 2'd2, 21'h080400, 32'h11112222, 1'b0);
    check(rd_data, 32'hDEADBEEF, "R14 rd_data held over write");
    check(top_ofs, 32'h11112222, "R5 top rewritten");

    // Interrupt
    pulse_tick();
    check(32'(irq), 32'd1, "R12 set by frame pulse");
    bus(1'b0, 2'd2, 21'h000000, 32'h0, 1'b0);
    check(32'(irq), 32'd1, "R12 read keeps irq");
    bus(1'b1, 2'd2, 21'h0FFFFC, 32'h1, 1'b0);
    check(32'(irq), 32'd0, "R12 unmapped write clears irq");
    bus(1'b1, 2'd2, 21'h080108, 32'h5, 1'b1);
    check(32'(irq), 32'd1, "R12 pulse wins over write");

    // Reset strobe with a simultaneous pulse
    bus(1'b1, 2'd2, 21'h180000, 32'h0, 1'b1);
    check(32'(irq),  32'd0, "R13 irq cleared");
    check(width_px,  32'd0, "R13 width cleared");
    check(height_ln, 32'd0, "R13 height cleared");
    check(top_ofs,   32'd0, "R13 top cleared");
    check(32'(depth_bpp), 32'd1, "R13 control cleared");
    pal_idx = 8'd1; cpal_sel = 2'd1; cpat_idx = 9'd1; #1;
    check(32'(pal_rgb),  32'd0, "R13 palette cleared");
    check(32'(cpal_rgb), 32'd0, "R13 cursor colour cleared");
    check(32'(cpat_row), 32'd0, "R13 cursor row cleared");
    bus(1'b0, 2'd2, 21'h000000, 32'h0, 1'b0);
    check(rd_data, 32'h00000010, "R1 id after clear");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule